// File: doc/BRIEF.md
# Receive Statistics Counter Unit

This unit keeps two saturating 16-bit statistics for a 100 Mb/s physical-layer receiver. It watches one-cycle status strobes from the receive decoder: frame start, a flag saying whether the start delimiter at that start was valid, symbol error, premature end of frame, and normal frame end. From these strobes it counts two things. The first is disconnect events, meaning frames that start without a valid J/K delimiter while the repeater-mode input is high. The second is frames that carried at least one receive error.

Software reads each count through a plain register read port. The port has a read strobe and a one-bit select, and the data comes back combinationally in the same cycle. A read clears the selected count at the next clock edge. If an event arrives in the same cycle as the read, that event survives as a count of one.

The read port has no valid/ready handshake and no back-pressure. A read is accepted in the cycle its strobe is high. The status strobes are plain control pins.

Top module: `rxstat_counters`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both counts to zero and discards any open-frame state. After reset, a read of either count returns 0.
- R2: When `repeater_mode` is 1, a cycle with `frm_start`=1 and `sd_valid`=0 adds one to the disconnect count. A cycle with `frm_start`=1 and `sd_valid`=1 adds nothing.
- R3: When `repeater_mode` is 0, disconnect detection is off and the disconnect count holds its value.
- R4: A frame that contains one or more `sym_err` strobes adds exactly one to the error-frame count. The count is taken when the frame closes with `frm_end`.
- R5: `early_end` both closes the open frame and marks it as errored, so it adds one to the error-frame count even when no symbol error came before it.
- R6: A frame that closes with `frm_end` and had no error leaves the error-frame count unchanged. The error mark is cleared at every frame close.
- R7: Neither count wraps. At 0xFFFF a count holds until it is read or reset.
- R8: While `rd_stb` is 1, `rd_data` returns the disconnect count when `rd_sel`=0 and the error-frame count when `rd_sel`=1, in the same cycle. While `rd_stb` is 0, `rd_data` is 0.
- R9: A read clears only the selected count, at the next clock edge. The other count is untouched.
- R10: If a read and an increment of the same count fall in one cycle, the read returns the old value and the count becomes 1.
- R11: `sym_err` or `early_end` outside an open frame is ignored. An open frame runs from `frm_start` up to its closing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| repeater_mode | input | 1 | Enables disconnect detection |
| frm_start | input | 1 | Frame start strobe |
| sd_valid | input | 1 | Start delimiter valid, sampled with frm_start |
| sym_err | input | 1 | Symbol error strobe |
| early_end | input | 1 | Premature end of frame strobe |
| frm_end | input | 1 | Normal frame end strobe |
| rd_stb | input | 1 | Read strobe; clears the selected count |
| rd_sel | input | 1 | 0 = disconnect count, 1 = error-frame count |
| rd_data | output | 16 | Selected count while rd_stb is high, else 0 |

## Verification
The bench drives the following frame patterns:
- A frame with two symbol errors, which shows that counting is once per frame and not once per error.
- A clean frame after an errored one, which shows that the error mark is cleared.
- A frame closed only by a premature end, which shows that this strobe alone marks the frame as errored.
- A stray symbol error between frames, which shows that errors outside a frame are ignored.

For the disconnect count, delimiter-less starts are driven with repeater mode on and off to separate the two cases. Tens of thousands of back-to-back starts push the count past its top value. Reads that coincide with increments on either count separate event-preserving clear-on-read from a plain clear.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_CNT = 2;

  typedef enum logic {
    SEL_DISC = 1'b0,
    SEL_ERRF = 1'b1
  } cnt_sel_e;
endpackage

// File: rtl/rxstat_frame_tracker.sv
module rxstat_frame_tracker (
  input  logic clk,
  input  logic rst,
  input  logic frm_start,
  input  logic sym_err,
  input  logic early_end,
  input  logic frm_end,
  output logic err_frame_inc
);
  logic in_frame_q, err_mark_q;
  logic active, err_now, close;

  // A frame is open from its start strobe (that cycle included) until it closes.
  assign active  = in_frame_q | frm_start;
  assign err_now = active & (sym_err | early_end);
  assign close   = active & (frm_end | early_end);

  assign err_frame_inc = close & (err_mark_q | err_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      err_mark_q <= 1'b0;
    end else begin
      if (close)          in_frame_q <= 1'b0;
      else if (frm_start) in_frame_q <= 1'b1;

      if (close)          err_mark_q <= 1'b0;
      else if (err_now)   err_mark_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxstat_disc_detect.sv
module rxstat_disc_detect (
  input  logic repeater_mode,
  input  logic frm_start,
  input  logic sd_valid,
  output logic disc_inc
);
  // A start without a J/K delimiter counts only while repeating.
  assign disc_inc = repeater_mode & frm_start & ~sd_valid;
endmodule

// File: rtl/rxstat_sat_counter.sv
module rxstat_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = inc ? ONE : '0;
    else if (inc && cnt_q != TOP) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rxstat_counters.sv
module rxstat_counters #(
  parameter int CNT_W = rxstat_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             repeater_mode,
  input  logic             frm_start,
  input  logic             sd_valid,
  input  logic             sym_err,
  input  logic             early_end,
  input  logic             frm_end,
  input  logic             rd_stb,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  import rxstat_pkg::*;
  localparam int N = NUM_CNT;

  logic [N-1:0]     inc_vec;
  logic [N-1:0]     clr_vec;
  logic [CNT_W-1:0] cnt_q [N];
  logic             disc_inc, errf_inc;

  rxstat_disc_detect u_disc (
    .repeater_mode (repeater_mode),
    .frm_start     (frm_start),
    .sd_valid      (sd_valid),
    .disc_inc      (disc_inc)
  );

  rxstat_frame_tracker u_frame (
    .clk           (clk),
    .rst           (rst),
    .frm_start     (frm_start),
    .sym_err       (sym_err),
    .early_end     (early_end),
    .frm_end       (frm_end),
    .err_frame_inc (errf_inc)
  );

  assign inc_vec[SEL_DISC] = disc_inc;
  assign inc_vec[SEL_ERRF] = errf_inc;

  for (genvar i = 0; i < N; i++) begin : g_cnt
    assign clr_vec[i] = rd_stb && (rd_sel == 1'(i));

    rxstat_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc_vec[i]),
      .clr   (clr_vec[i]),
      .count (cnt_q[i])
    );
  end

  assign rd_data = rd_stb ? cnt_q[rd_sel] : '0;
endmodule

// File: rtl/rxstat_counters_chk.sv
module rxstat_counters_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             repeater_mode,
  input logic             frm_start,
  input logic             rd_stb,
  input logic             rd_sel,
  input logic [CNT_W-1:0] disc_cnt,
  input logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R1: reset empties both counts
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (disc_cnt == '0 && err_cnt == '0));

  // R3: disconnect count frozen while not repeating
  a_r3_hold_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (!repeater_mode && !(rd_stb && !rd_sel)) |=> $stable(disc_cnt));

  // R4: error-frame count steps by at most one per cycle
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && rd_sel) |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

  // R7: a full count stays full when not read
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (disc_cnt == TOP && !(rd_stb && !rd_sel)) |=> disc_cnt == TOP);

  // R9: read without a coincident start empties the disconnect count
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_sel && !frm_start) |=> disc_cnt == '0);
endmodule

bind rxstat_counters rxstat_counters_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .repeater_mode (repeater_mode),
  .frm_start     (frm_start),
  .rd_stb        (rd_stb),
  .rd_sel        (rd_sel),
  .disc_cnt      (cnt_q[0]),
  .err_cnt       (cnt_q[1])
);

// File: tb/rxstat_counters_tb.sv
module rxstat_counters_tb;
  localparam int W     = 16;
  localparam int NVEC  = 18;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic repeater_mode = 1'b0, frm_start = 1'b0, sd_valid = 1'b0;
  logic sym_err = 1'b0, early_end = 1'b0, frm_end = 1'b0;
  logic rd_stb = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] rd_data;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxstat_counters u_dut (
    .clk(clk), .rst(rst), .repeater_mode(repeater_mode), .frm_start(frm_start),
    .sd_valid(sd_valid), .sym_err(sym_err), .early_end(early_end),
    .frm_end(frm_end), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // Vector fields: {rep,start,sdv,serr,eend,fend,rd,sel} then expected rd_data.
  localparam logic [23:0] VEC [NVEC] = '{
    {8'b1110_0000, 16'h0000},  // good start
    {8'b1001_0000, 16'h0000},  // symbol error
    {8'b1001_0000, 16'h0000},  // second symbol error
    {8'b1000_0100, 16'h0000},  // frame end
    {8'b1000_0011, 16'h0001},  // R4 one count for two errors
    {8'b1100_0000, 16'h0000},  // start without J/K
    {8'b1000_0100, 16'h0000},  // clean end
    {8'b1000_0011, 16'h0000},  // R6 clean frame not counted
    {8'b1000_0010, 16'h0001},  // R2 disconnect counted
    {8'b0100_0000, 16'h0000},  // start without J/K, not repeating
    {8'b0000_1000, 16'h0000},  // premature end
    {8'b0000_0010, 16'h0000},  // R3 no disconnect off repeater
    {8'b0000_0011, 16'h0001},  // R5 premature end counted
    {8'b0001_0000, 16'h0000},  // stray symbol error
    {8'b1110_0000, 16'h0000},  // good start
    {8'b1000_0100, 16'h0000},  // clean end
    {8'b1000_0011, 16'h0000},  // R11 stray error ignored
    {8'b1000_0000, 16'h0000}   // R8 idle read port is zero
  };

  task automatic drive(input logic [7:0] c);
    @(negedge clk);
    {repeater_mode, frm_start, sd_valid, sym_err, early_end, frm_end, rd_stb, rd_sel} = c;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: rd_data=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic sel, input logic [W-1:0] exp, input string req);
    drive({7'b1000_001, sel});
    check(req, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, LIMIT);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(1'b0, 16'h0000, "R1 disc after reset");
    rd(1'b1, 16'h0000, "R1 errf after reset");

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][23:16]);
      check($sformatf("vector %0d", i), rd_data, VEC[i][15:0]);
    end

    // R10 read and disconnect in the same cycle
    drive(8'b1100_0000);
    drive(8'b1100_0000);
    drive(8'b1100_0010);
    check("R10 disc old value", rd_data, 16'h0002);
    rd(1'b0, 16'h0001, "R10 disc event kept");

    // R10 read and error-frame close in the same cycle
    drive(8'b1110_1000);
    drive(8'b1110_0000);
    drive(8'b1001_0000);
    drive(8'b1000_0111);
    check("R10 errf old value", rd_data, 16'h0001);
    rd(1'b1, 16'h0001, "R10 errf event kept");

    // R9 reading one count leaves the other
    drive(8'b1110_1000);
    drive(8'b1100_0000);
    rd(1'b0, 16'h0001, "R9 disc read");
    rd(1'b1, 16'h0001, "R9 errf untouched");

    // R1 reset mid-run
    drive(8'b1100_0000);
    drive(8'b1110_1000);
    @(negedge clk) rst = 1'b1;
    {repeater_mode, frm_start, sd_valid, sym_err, early_end, frm_end, rd_stb, rd_sel} = '0;
    @(negedge clk) rst = 1'b0;
    rd(1'b0, 16'h0000, "R1 disc cleared");
    rd(1'b1, 16'h0000, "R1 errf cleared");

    // R7 saturation of the disconnect count
    for (int k = 0; k < 65540; k++) drive(8'b1100_0000);
    rd(1'b0, 16'hFFFF, "R7 held at top");
    rd(1'b0, 16'h0000, "R9 cleared after full read");

    drive(8'b0000_0000);
    finish_run();
  end
endmodule